// File: doc/BRIEF.md
# Cascaded Clock Divider Chain

This block derives the clocks of a memory domain from one already selected source clock. Integer dividers are chained, so each ratio is relative to the stage that feeds it. The main branch has three stages. A core memory clock is divided from the source, a data-bus clock is divided from the core memory clock, and a register-bus clock is divided from the data-bus clock. A second branch from the same source gives a coherency-port bus clock. Below it sits that bus's peripheral clock, held at a fixed ratio.

The whole chain runs on one reference clock. The source is described by a strobe, `src_en`, that is high for one reference cycle per source-clock cycle. Every stage outputs a period-start strobe and a duty-shaped level, and both are usable as clock enables or as a divided clock waveform. Divide values are written at run time through a small write port. A new value waits until the end of the stage's current output period, so no period is ever shortened. Each stage reports a busy bit while a change is pending. A write that breaks the core-to-data-bus ratio rule is refused. So is a write to the fixed stage or to a missing stage.

Top module: `clkdiv_chain`

## Requirements
- R1: After reset every programmable stage divides by 1, the peripheral stage (index 4) divides by 2, and all busy bits and `cfg_rej` are 0.
- R2: A divide code c gives n = c+1, so the period of a stage's `div_tick` is n times its input period. Stage 0 takes a 4-bit code (n from 1 to 16). The other stages use only code bits [2:0] (n from 1 to 8), and bit 3 is ignored for them.
- R3: The inputs are wired as follows: stage 0 and stage 3 take the source, stage 1 takes stage 0, stage 2 takes stage 1, and stage 4 takes stage 3. Every tick of a stage falls on a tick of its input.
- R4: For n >= 2, `div_clk` is high for floor(n/2) of the n input cycles in each period. For n = 1, `div_clk` follows the input level. The level of the source is `src_en`.
- R5: `cfg_sel` picks the stage index 0..4 for a write made with `cfg_we` high.
- R6: `div_busy` of a stage rises in the cycle after an accepted write. It falls after the last input cycle of the current output period, and the new ratio takes effect from the next period. The period in progress completes with the old ratio.
- R7: Stage 1 (data bus) accepts only the masked codes 0 and 1, which give a ratio of 1:1 or 2:1. Any other code is refused: `cfg_rej` pulses high in the next cycle and no setting changes.
- R8: Writes to the fixed stage 4 and to indices 5..7 are refused in the same way.
- R9: When `src_en` is low, no stage ticks.
- R10: A second accepted write to a stage that is still busy replaces the pending value, so the last write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_en | input | 1 | Source-clock cycle strobe, also the source level |
| cfg_we | input | 1 | Write strobe for a divide code |
| cfg_sel | input | 3 | Stage index of the write |
| cfg_code | input | 4 | Divide code, n-1 |
| div_tick | output | 5 | Per-stage output period start strobe |
| div_clk | output | 5 | Per-stage divided clock level |
| div_busy | output | 5 | Per-stage pending-change flag |
| cfg_rej | output | 1 | One-cycle pulse for a refused write |

## Verification
Most state errors become visible within one output period. A corrupted counter or ratio in any stage shows up as a wrong spacing between ticks, and the wrong spacing carries through the ticks of every stage below it. A duty error shows up as a wrong count of high cycles within the next period. A bad pending value or busy flag shows up later. It appears either as a ratio that changes in the middle of a period, which shortens that period, or as a busy bit that stays high after the boundary, so the bench measures the period in progress and the one after each write. The ratio guard is checked through `cfg_rej` one cycle after the write, and also through the unchanged periods that follow.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int NST      = 5;   // stages in the domain
  localparam int CODE_W   = 4;   // widest divide code field
  localparam int SEL_W    = 3;   // stage select width
  localparam int NARROW_W = 3;   // code width of the 1..8 stages
  localparam int RATIO_STAGE = 1;  // data-bus stage bound to the core clock
  localparam int RATIO_MAX   = 1;  // highest code allowed there (2:1)
  localparam int FIX_CODE    = 1;  // fixed stage divides by 2

  // input of each stage, -1 for the selected source
  function automatic int parent_of(input int idx);
    case (idx)
      1:       return 0;
      2:       return 1;
      4:       return 3;
      default: return -1;
    endcase
  endfunction

  function automatic bit is_wide(input int idx);
    return idx == 0;
  endfunction

  function automatic bit is_fixed(input int idx);
    return idx == 4;
  endfunction

  // input cycles with the output high for code c (n = c+1)
  function automatic logic [CODE_W-1:0] high_len(input logic [CODE_W-1:0] code);
    logic [CODE_W:0] n;
    n = {1'b0, code} + 1'b1;
    return CODE_W'(n >> 1);
  endfunction

  function automatic logic [CODE_W-1:0] narrow_mask();
    return CODE_W'((1 << NARROW_W) - 1);
  endfunction
endpackage

// File: rtl/clkdiv_stage.sv
module clkdiv_stage #(
  parameter int CW       = 4,
  parameter bit FIXED    = 1'b0,
  parameter int FIX_CODE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_tick,
  input  logic          in_lvl,
  input  logic          ld_en,
  input  logic [CW-1:0] ld_code,
  output logic          out_tick,
  output logic          out_lvl,
  output logic          busy,
  output logic          bound,
  output logic [CW-1:0] cur_code
);
  localparam logic [CW-1:0] RST_CODE = FIXED ? CW'(FIX_CODE) : '0;

  logic [CW-1:0] cnt;
  logic [CW-1:0] pend;

  // last input cycle of the current output period
  assign bound    = in_tick && (cnt == cur_code);
  assign out_tick = in_tick && (cnt == '0);
  assign out_lvl  = (cur_code == '0) ? in_lvl
                                     : (cnt < clkdiv_pkg::high_len(cur_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      cur_code <= RST_CODE;
      pend     <= RST_CODE;
      busy     <= 1'b0;
    end else begin
      if (in_tick) cnt <= bound ? '0 : cnt + 1'b1;
      if (ld_en && !FIXED) begin
        pend <= ld_code;
        busy <= 1'b1;
      end else if (busy && bound) begin
        cur_code <= pend;
        busy     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg #(
  parameter int NST = 5,
  parameter int CW  = 4,
  parameter int SW  = 3
) (
  input  logic           cfg_we,
  input  logic [SW-1:0]  cfg_sel,
  input  logic [CW-1:0]  cfg_code,
  output logic [NST-1:0] ld_en,
  output logic [CW-1:0]  ld_code,
  output logic           rej
);
  int sel_i;
  assign sel_i = int'(cfg_sel);

  always_comb begin
    ld_en   = '0;
    rej     = 1'b0;
    ld_code = cfg_code;
    if (cfg_we) begin
      if (sel_i >= NST) begin
        rej = 1'b1;
      end else begin
        if (!clkdiv_pkg::is_wide(sel_i)) ld_code = cfg_code & clkdiv_pkg::narrow_mask();
        if (clkdiv_pkg::is_fixed(sel_i))
          rej = 1'b1;
        else if (sel_i == clkdiv_pkg::RATIO_STAGE && int'(ld_code) > clkdiv_pkg::RATIO_MAX)
          rej = 1'b1;
        else
          ld_en[sel_i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkdiv_chain.sv
module clkdiv_chain
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_en,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [CODE_W-1:0] cfg_code,
  output logic [NST-1:0]    div_tick,
  output logic [NST-1:0]    div_clk,
  output logic [NST-1:0]    div_busy,
  output logic              cfg_rej
);
  logic [NST-1:0]             ld_en;
  logic [CODE_W-1:0]          ld_code;
  logic                       rej_w;
  logic [NST-1:0]             in_tick_w;
  logic [NST-1:0]             in_lvl_w;
  logic [NST-1:0]             bound_w;
  logic [NST-1:0][CODE_W-1:0] cur_w;

  clkdiv_cfg #(.NST(NST), .CW(CODE_W), .SW(SEL_W)) u_cfg (
    .cfg_we  (cfg_we),
    .cfg_sel (cfg_sel),
    .cfg_code(cfg_code),
    .ld_en   (ld_en),
    .ld_code (ld_code),
    .rej     (rej_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_rej <= 1'b0;
    else        cfg_rej <= rej_w;
  end

  for (genvar i = 0; i < NST; i++) begin : g_st
    localparam int PAR = parent_of(i);
    if (PAR < 0) begin : g_root
      assign in_tick_w[i] = src_en;
      assign in_lvl_w[i]  = src_en;
    end else begin : g_child
      assign in_tick_w[i] = div_tick[PAR];
      assign in_lvl_w[i]  = div_clk[PAR];
    end

    clkdiv_stage #(
      .CW      (CODE_W),
      .FIXED   (is_fixed(i)),
      .FIX_CODE(FIX_CODE)
    ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_tick (in_tick_w[i]),
      .in_lvl  (in_lvl_w[i]),
      .ld_en   (ld_en[i]),
      .ld_code (ld_code),
      .out_tick(div_tick[i]),
      .out_lvl (div_clk[i]),
      .busy    (div_busy[i]),
      .bound   (bound_w[i]),
      .cur_code(cur_w[i])
    );
  end
endmodule

// File: rtl/clkdiv_chain_chk.sv
module clkdiv_chain_chk
  import clkdiv_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       src_en,
  input logic                       cfg_we,
  input logic                       cfg_rej,
  input logic [NST-1:0]             div_tick,
  input logic [NST-1:0]             div_busy,
  input logic [NST-1:0]             ld_en,
  input logic [NST-1:0]             bound_w,
  input logic [NST-1:0][CODE_W-1:0] cur_w
);
  a_r9_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !src_en |-> (div_tick == '0));

  a_r7_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cur_w[RATIO_STAGE]) <= RATIO_MAX);

  a_r7_rej_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rej |-> $past(cfg_we));

  a_r8_fixed_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cur_w[4]));

  for (genvar i = 0; i < NST; i++) begin : g_a
    a_r6_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en[i] |=> div_busy[i]);

    a_r6_busy_clear_at_bound: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(div_busy[i]) |-> $past(bound_w[i]));

    a_r6_ratio_moves_at_bound: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_w[i]) |-> $past(bound_w[i]));

    if (parent_of(i) >= 0) begin : g_par
      a_r3_tick_on_parent: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick[i] |-> div_tick[parent_of(i)]);
    end
  end
endmodule

bind clkdiv_chain clkdiv_chain_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .src_en  (src_en),
  .cfg_we  (cfg_we),
  .cfg_rej (cfg_rej),
  .div_tick(div_tick),
  .div_busy(div_busy),
  .ld_en   (ld_en),
  .bound_w (bound_w),
  .cur_w   (cur_w)
);

// File: tb/clkdiv_chain_test.sv
module clkdiv_chain_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_en = 1'b1;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [3:0] cfg_code = '0;
  logic [4:0] div_tick, div_clk, div_busy;
  logic       cfg_rej;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int src_gap = 1;   // reference cycles per source cycle
  int ph      = 0;
  int nv[5]   = '{1, 1, 1, 1, 2};
  localparam int PAR[5] = '{-1, 0, 1, -1, 3};

  localparam int NV = 13;
  localparam int V_SEL[NV]  = '{0, 1, 2, 1, 3, 4, 0, 2, 5, 1, 1, 0, 7};
  localparam int V_CODE[NV] = '{3, 1, 2, 2, 4, 0, 15, 15, 1, 9, 0, 0, 0};
  localparam bit V_REJ[NV]  = '{0, 0, 0, 1, 0, 1, 0, 0, 1, 0, 0, 0, 1};

  clkdiv_chain uut (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_code(cfg_code), .div_tick(div_tick),
    .div_clk(div_clk), .div_busy(div_busy), .cfg_rej(cfg_rej)
  );

  always #10 clk = ~clk;

  initial forever begin
    @(posedge clk);
    #2;
    ph = (ph + 1 >= src_gap) ? 0 : ph + 1;
    src_en = (ph == 0);
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int mod_per(input int i);
    return (PAR[i] < 0) ? src_gap * nv[i] : mod_per(PAR[i]) * nv[i];
  endfunction

  function automatic int mod_high(input int i);
    int pp, ph_in;
    pp    = (PAR[i] < 0) ? src_gap : mod_per(PAR[i]);
    ph_in = (PAR[i] < 0) ? 1 : mod_high(PAR[i]);
    return (nv[i] >= 2) ? (nv[i] / 2) * pp : ph_in;
  endfunction

  task automatic wait_tick(input int i);
    int g = 0;
    while (!div_tick[i] && g < 3000) begin @(negedge clk); g++; end
  endtask

  task automatic measure(input int i, output int p, output int h);
    wait_tick(i);
    @(negedge clk);
    wait_tick(i);
    p = 0; h = 0;
    do begin
      h += div_clk[i];
      p++;
      @(negedge clk);
    end while (!div_tick[i] && p < 3000);
  endtask

  task automatic check_all(input string tag);
    int p, h;
    for (int i = 0; i < 5; i++) begin
      measure(i, p, h);
      chk(p == mod_per(i),  $sformatf("R2/R3 %s period stage %0d", tag, i), p, mod_per(i));
      chk(h == mod_high(i), $sformatf("R4 %s high stage %0d", tag, i), h, mod_high(i));
    end
  endtask

  task automatic write(input int sel, input int code);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_code = 4'(code);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    int c, p, h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(div_busy == 5'b0, "R1 busy after reset", div_busy, 0);
    chk(cfg_rej == 1'b0, "R1 rej after reset", cfg_rej, 0);
    check_all("reset R1");

    // vector walk: R5, R7, R8, R2
    for (int v = 0; v < NV; v++) begin
      write(V_SEL[v], V_CODE[v]);
      chk(cfg_rej == V_REJ[v], $sformatf("R5/R7/R8 rej vec %0d", v), cfg_rej, V_REJ[v]);
      if (V_SEL[v] < 5)
        chk(div_busy[V_SEL[v]] == !V_REJ[v], $sformatf("R6 busy set vec %0d", v),
            div_busy[V_SEL[v]], !V_REJ[v]);
      if (!V_REJ[v]) begin
        nv[V_SEL[v]] = (V_SEL[v] == 0) ? V_CODE[v] + 1 : (V_CODE[v] & 7) + 1;
        c = 0;
        while (div_busy[V_SEL[v]] && c < 3000) begin @(negedge clk); c++; end
        chk(!div_busy[V_SEL[v]], $sformatf("R6 busy clear vec %0d", v), div_busy[V_SEL[v]], 0);
      end
      check_all($sformatf("vec %0d", v));
    end

    // R6: period in progress completes with old ratio (stage 3, n 5 -> 2)
    wait_tick(3);
    cfg_we = 1'b1; cfg_sel = 3'd3; cfg_code = 4'd1;
    @(negedge clk);
    cfg_we = 1'b0;
    c = 1;
    chk(div_busy[3], "R6 busy during period", div_busy[3], 1);
    while (!div_tick[3] && c < 100) begin @(negedge clk); c++; end
    chk(c == 5, "R6 old period kept", c, 5);
    chk(!div_busy[3], "R6 busy clear at boundary", div_busy[3], 0);
    @(negedge clk);
    c = 1;
    while (!div_tick[3] && c < 100) begin @(negedge clk); c++; end
    chk(c == 2, "R6 new period", c, 2);
    nv[3] = 2;

    // R10: last write wins on stage 2
    write(2, 3);
    write(2, 5);
    c = 0;
    while (div_busy[2] && c < 3000) begin @(negedge clk); c++; end
    nv[2] = 6;
    measure(2, p, h);
    chk(p == mod_per(2), "R10 last write period", p, mod_per(2));
    chk(h == mod_high(2), "R10 last write high", h, mod_high(2));

    // R9: slower source, no ticks while src_en low
    src_gap = 3;
    repeat (4) @(negedge clk);
    check_all("slow src R9");
    c = 0;
    for (int k = 0; k < 60; k++) begin
      if (!src_en && div_tick != 5'b0) c++;
      @(negedge clk);
    end
    chk(c == 0, "R9 ticks while source idle", c, 0);

    summary();
    $finish;
  end
endmodule